// File: doc/BRIEF.md
# Dual-Modulus Programmable Frequency Divider

This block divides its input clock by a programmable ratio N and emits a single-cycle pulse once every N input clocks. It is meant for the feedback path of a frequency synthesizer, where the divided pulse goes to a phase comparator. The ratio arrives as a binary word or, when a parameter selects it, as packed decimal digits (four bits per digit, least significant digit in bits 3:0).

Inside, a fast prescaler divides by either 10 or 11. It is built as a divide-by-5/6 stage followed by a divide-by-2 stage. A control state machine holds two counters. The main counter counts prescaler cycles, and the swallow counter counts the prescaler cycles that still run at 11. The block splits N as N = 10·M + A, with A < 10. The first A prescaler cycles of every division run at 11 and the remaining M − A cycles run at 10. A zero detector on the swallow counter switches the prescaler to the low modulus.

The reload is decided early. While the main counter holds 1, the prescaler cycle in progress is known to be the last one. At the end of that cycle both counters are reloaded from the ratio present at that moment, and the output pulse is raised. Any N below 90, the smallest value above which every ratio can be split with M ≥ A, is replaced by 90 and flagged.

Top module: `dmd_divider`

Control states (`ctrl_state_t`):
- `CS_START`: entered on reset, with the prescaler held. It always goes to `CS_SWALLOW` when A ≠ 0, and to `CS_MAIN` otherwise.
- `CS_SWALLOW`: prescaler at 11. At a prescaler end:
  - on early decode it reloads, going to `CS_SWALLOW` or `CS_MAIN` by the new A;
  - when the swallow count reaches zero it goes to `CS_MAIN`.
- `CS_MAIN`: prescaler at 10. At a prescaler end with early decode it reloads the same way.

Prescaler half states (`pre_phase_t`):
- `PH_FIRST` always lasts 5 clocks.
- `PH_SECOND` lasts 6 clocks in `CS_SWALLOW` and 5 clocks otherwise. Each half hands over to the other at its last clock.

## Requirements
- R1: `div_pulse` is high for exactly one clock and is never high on two consecutive clocks.
- R2: For a binary ratio N with 90 ≤ N ≤ 2^NW − 1, consecutive rising edges of `div_pulse` are exactly N clocks apart.
- R3: A ratio below 90, including 0, gives a period of exactly 90 clocks. `n_clamped` is high during the period that follows a pulse whose reload captured such a ratio, and low when the captured ratio is 90 or more.
- R4: The ratio is sampled only at the clock edge that raises `div_pulse`. A change to `n_value` at any other time does not alter the period in progress; it sets the length of the period that starts at the next pulse.
- R5: While `rst` is high, `div_pulse` and `n_clamped` are 0. Count the first rising edge that samples `rst` low as edge 1. The first pulse after reset is then high right after edge N+1, where N is the effective ratio sampled at edge 1.
- R6: With `USE_BCD` = 1, `n_value` holds decimal digits, four bits each, with the least significant digit in bits 3:0. The period equals the decimal value, with the same clamp at 90.
- R7: `n_clamped` changes only on the clock edge that raises `div_pulse`; it is stable between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| n_value | input | NW | Division ratio, binary or packed decimal per `USE_BCD` |
| div_pulse | output | 1 | One-clock pulse every N clocks |
| n_clamped | output | 1 | Ratio of the current period was raised to the minimum |

## Verification
A wrong prescaler slot count shows at the very next pulse as a period off by one clock for each affected prescaler cycle. A wrong main or swallow count shifts the period by a multiple of ten, or by one per swallowed cycle. Either error is visible within one division period of the fault. A reload taken from the wrong moment shows up when the ratio changes mid-period: the period then reflects the new value one pulse too early. An unstable clamp flag shows as a change between pulses.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    typedef enum logic [1:0] {
        CS_START   = 2'd0,
        CS_SWALLOW = 2'd1,
        CS_MAIN    = 2'd2
    } ctrl_state_t;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } pre_phase_t;

endpackage

// File: rtl/dmd_ratio_decode.sv
module dmd_ratio_decode #(
    parameter int NW       = 10,
    parameter bit USE_BCD  = 1'b0,
    parameter int PRE_BASE = 5,
    parameter int AW       = $clog2(2 * PRE_BASE)
) (
    input  logic [NW-1:0] n_in,
    output logic [NW-1:0] m_val,
    output logic [AW-1:0] a_val,
    output logic          clamp
);
    localparam int LOW_MOD = 2 * PRE_BASE;
    localparam int N_MIN   = LOW_MOD * (LOW_MOD - 1);
    localparam int NDIG    = NW / 4;
    localparam logic [NW-1:0] LOW_V  = NW'(LOW_MOD);
    localparam logic [NW-1:0] NMIN_V = NW'(N_MIN);

    logic [NW-1:0] n_bin;
    logic [NW-1:0] eff;

    generate
        if (USE_BCD) begin : g_bcd
            always_comb begin
                int acc;
                int w;
                acc = 0;
                w   = 1;
                for (int k = 0; k < NDIG; k++) begin
                    acc = acc + int'(n_in[4*k +: 4]) * w;
                    w   = w * 10;
                end
                n_bin = NW'(acc);
            end
        end else begin : g_bin
            assign n_bin = n_in;
        end
    endgenerate

    always_comb begin
        clamp = (n_bin < NMIN_V);
        eff   = clamp ? NMIN_V : n_bin;
        m_val = eff / LOW_V;
        a_val = AW'(eff % LOW_V);
    end

endmodule

// File: rtl/dmd_prescaler.sv
module dmd_prescaler
    import dmd_pkg::*;
#(
    parameter int PRE_BASE = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic high,
    output logic pre_tick
);
    localparam int QW = $clog2(PRE_BASE + 1);

    pre_phase_t    ph;
    pre_phase_t    ph_nxt;
    logic [QW-1:0] q;
    logic [QW-1:0] last_q;

    // Only the second half may stretch by one slot, giving 10 or 11 overall
    always_comb begin
        last_q = (ph == PH_SECOND && high) ? QW'(PRE_BASE) : QW'(PRE_BASE - 1);
        ph_nxt = ph;
        unique case (ph)
            PH_FIRST:  if (q == last_q) ph_nxt = PH_SECOND;
            PH_SECOND: if (q == last_q) ph_nxt = PH_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ph <= PH_FIRST;
            q  <= '0;
        end else begin
            ph <= ph_nxt;
            q  <= (q == last_q) ? '0 : q + QW'(1);
        end
    end

    assign pre_tick = (ph == PH_SECOND) && (q == last_q);

    assert_slot_bound_R2: assert property (@(posedge clk) disable iff (rst)
        q <= QW'(PRE_BASE));

    assert_extra_slot_high_R2: assert property (@(posedge clk) disable iff (rst)
        (q == QW'(PRE_BASE)) |-> (ph == PH_SECOND && high));

endmodule

// File: rtl/dmd_ctrl.sv
module dmd_ctrl
    import dmd_pkg::*;
#(
    parameter int CW = 10,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_tick,
    input  logic [CW-1:0] m_ld,
    input  logic [AW-1:0] a_ld,
    input  logic          clamp_ld,
    output logic          hold,
    output logic          high,
    output logic          pulse,
    output logic          clamped
);
    ctrl_state_t   state;
    ctrl_state_t   nxt;
    logic [CW-1:0] m_cnt;
    logic [AW-1:0] a_cnt;
    logic          early;
    logic          wrap;
    logic          reload;
    ctrl_state_t   entry;

    // Early decode: main count at 1 means the running prescaler cycle is the last
    assign early  = (m_cnt == CW'(1));
    assign wrap   = (state != CS_START) && pre_tick && early;
    assign reload = (state == CS_START) || wrap;
    assign entry  = (a_ld != '0) ? CS_SWALLOW : CS_MAIN;

    always_comb begin
        nxt = state;
        unique case (state)
            CS_START:   nxt = entry;
            CS_SWALLOW: begin
                if (pre_tick) begin
                    if (early)                   nxt = entry;
                    else if (a_cnt == AW'(1))    nxt = CS_MAIN;
                end
            end
            CS_MAIN:    if (pre_tick && early) nxt = entry;
            default:    nxt = CS_START;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CS_START;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_cnt <= '0;
            a_cnt <= '0;
        end else if (reload) begin
            m_cnt <= m_ld;
            a_cnt <= a_ld;
        end else if (pre_tick) begin
            m_cnt <= m_cnt - CW'(1);
            if (a_cnt != '0) a_cnt <= a_cnt - AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse   <= 1'b0;
            clamped <= 1'b0;
        end else begin
            pulse <= wrap;
            if (wrap) clamped <= clamp_ld;
        end
    end

    assign hold = (state == CS_START);
    assign high = (state == CS_SWALLOW);

    assert_one_cycle_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

    assert_zero_detect_state_R2: assert property (@(posedge clk) disable iff (rst)
        (state != CS_START) |-> ((state == CS_SWALLOW) == (a_cnt != '0)));

    assert_main_count_live_R2: assert property (@(posedge clk) disable iff (rst)
        (state != CS_START) |-> (m_cnt != '0));

    assert_swallow_within_main_R2: assert property (@(posedge clk) disable iff (rst)
        (state != CS_START) |-> (CW'(a_cnt) <= m_cnt));

    assert_flag_moves_with_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(clamped) |-> pulse);

endmodule

// File: rtl/dmd_divider.sv
module dmd_divider #(
    parameter int NW       = 10,
    parameter bit USE_BCD  = 1'b0,
    parameter int PRE_BASE = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] n_value,
    output logic          div_pulse,
    output logic          n_clamped
);
    localparam int AW = $clog2(2 * PRE_BASE);

    logic [NW-1:0] m_val;
    logic [AW-1:0] a_val;
    logic          clamp;
    logic          hold;
    logic          high;
    logic          pre_tick;

    dmd_ratio_decode #(
        .NW(NW), .USE_BCD(USE_BCD), .PRE_BASE(PRE_BASE), .AW(AW)
    ) u_dec (
        .n_in(n_value), .m_val(m_val), .a_val(a_val), .clamp(clamp)
    );

    dmd_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
        .clk(clk), .rst(rst), .hold(hold), .high(high), .pre_tick(pre_tick)
    );

    dmd_ctrl #(.CW(NW), .AW(AW)) u_ctl (
        .clk(clk), .rst(rst), .pre_tick(pre_tick),
        .m_ld(m_val), .a_ld(a_val), .clamp_ld(clamp),
        .hold(hold), .high(high), .pulse(div_pulse), .clamped(n_clamped)
    );

endmodule

// File: tb/sim_dmd_divider.sv
`timescale 1ns/1ps
module sim_dmd_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rst_q = 1'b1;
    logic [9:0]  n0 = 10'd90;
    logic [11:0] n1 = 12'h090;
    logic        p0, f0, p1, f1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    dmd_divider #(.NW(10), .USE_BCD(1'b0)) u0 (
        .clk(clk), .rst(rst), .n_value(n0), .div_pulse(p0), .n_clamped(f0));

    dmd_divider #(.NW(12), .USE_BCD(1'b1)) u1 (
        .clk(clk), .rst(rst), .n_value(n1), .div_pulse(p1), .n_clamped(f1));

    function automatic int per(input int n);
        return (n < 90) ? 90 : n;
    endfunction

    function automatic int bcd_to_bin(input logic [11:0] b);
        return int'(b[3:0]) + 10 * int'(b[7:4]) + 100 * int'(b[11:8]);
    endfunction

    function automatic logic [11:0] bin_to_bcd(input int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Watchdog and the reset view seen by the design at each edge
    always @(posedge clk) begin
        rst_q <= rst;
        cyc   <= cyc + 1;
        if (cyc >= 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    int cnt[2], n_act[2], n_prev[2];
    bit seen[2], prev_p[2], prev_f[2], chg[2];

    always @(negedge clk) begin
        for (int u = 0; u < 2; u++) begin
            int  cur;
            int  expv;
            bit  pp, ff;
            cur = (u == 0) ? int'(n0) : bcd_to_bin(n1);
            pp  = (u == 0) ? p0 : p1;
            ff  = (u == 0) ? f0 : f1;
            if (rst_q) begin
                chk(!pp && !ff, "R5 reset outputs", {30'd0, pp, ff}, 0);
                cnt[u] = 0; seen[u] = 0; prev_p[u] = 0; prev_f[u] = 0;
                chg[u] = 0; n_act[u] = cur;
            end else begin
                cnt[u]++;
                if (pp) begin
                    chk(!prev_p[u], "R1 back-to-back pulse", 1, 0);
                    expv = seen[u] ? per(n_act[u]) : per(n_act[u]) + 1;
                    if (!seen[u])      chk(cnt[u] == expv, "R5 first period", cnt[u], expv);
                    else if (u == 1)   chk(cnt[u] == expv, "R6 decimal period", cnt[u], expv);
                    else if (chg[u])   chk(cnt[u] == expv, "R4 period after change", cnt[u], expv);
                    else if (n_act[u] < 90) chk(cnt[u] == expv, "R3 clamped period", cnt[u], expv);
                    else               chk(cnt[u] == expv, "R2 period", cnt[u], expv);
                    chk(ff == (n_prev[u] < 90), "R3 clamp flag", int'(ff), int'(n_prev[u] < 90));
                    n_act[u] = n_prev[u];
                    chg[u] = 0; cnt[u] = 0; seen[u] = 1;
                end else begin
                    chk(ff == prev_f[u], "R7 flag stable between pulses", int'(ff), int'(prev_f[u]));
                end
                if (cur != n_act[u]) chg[u] = 1;
                prev_p[u] = pp;
                prev_f[u] = ff;
            end
            n_prev[u] = cur;
        end
    end

    task automatic step(input int v0, input int v1, input int hold_cycles);
        @(posedge clk); #1;
        n0 = 10'(v0);
        n1 = bin_to_bcd(v1);
        repeat (hold_cycles) @(posedge clk);
    endtask

    initial begin
        int d0 [8] = '{90, 1023, 0, 89, 91, 100, 99, 250};
        int d1 [8] = '{0, 999, 89, 90, 100, 99, 555, 91};
        void'($urandom(32'd20240611));
        repeat (6) @(posedge clk);
        #1 rst = 1'b0;
        // Directed corners: minimum, maximum, zero, just below and above the
        // minimum, A = 0, M = A
        for (int i = 0; i < 8; i++) step(d0[i], d1[i], 3 * 1030 + 20);
        // Random ratios, held for random spans so changes land mid-period (R4)
        for (int i = 0; i < 50; i++) begin
            int v0, v1;
            v0 = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 95)) : int'($urandom_range(90, 1023));
            v1 = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 95)) : int'($urandom_range(90, 999));
            step(v0, v1, int'($urandom_range(1, 1500)));
        end
        // Reset in the middle of a run (R5)
        @(posedge clk); #1 rst = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        step(123, 45, 3 * 130);
        step(700, 640, 2 * 710);
        repeat (1100) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule